// File: doc/BRIEF.md
# Translation Lookaside Buffer

This block is a small, fully associative store of recent translations from a virtual page to a physical frame. It sits between a requester and memory. The requester offers a 32-bit virtual address and an access kind (read, write or execute) with a valid strobe. It holds them until the buffer answers with a hit or a fault. Pages are 4 KB, so the low 12 address bits are the in-page offset. They are never translated. The upper 20 bits are the virtual page number, and that number is compared against every resident entry in parallel.

On a hit, the physical address is formed in the same cycle, with no memory traffic: the entry's frame number sits above the original offset. On a miss, the request stalls. The buffer asks an external page table walker for the mapping and installs the walker's answer. On the next cycle the held request hits.

Every entry keeps a referenced flag, a dirty flag, separate read, write and execute grants, and a cache-control field. Each hit updates the flags. An access whose kind is not granted faults instead of translating. A flush input invalidates every entry at once.

Top module: `xlate_buffer`

## Requirements
- R1: After reset no entry is valid. All response outputs and `walkReq` are 0, and the first request to any page misses.
- R2: A request whose page number matches a valid entry whose grants permit the access raises `respHit` in the same cycle. `respPaddr` then equals the entry's frame number concatenated above `reqVaddr[11:0]`, and no walk is started.
- R3: A request that matches no valid entry raises `respStall` in the same cycle. From the next cycle `walkReq` is 1 and `walkVpn` carries `reqVaddr[31:12]`. `walkReq` stays 1 until `refillValid` is seen.
- R4: A refill is accepted in a cycle where `walkReq` and `refillValid` are both 1. `walkReq` is 0 in the following cycle, and the held request hits in that same following cycle. A miss therefore resolves two cycles after it is first presented.
- R5: Every hit sets the entry's referenced flag. `respWasRef` shows the flag as it stood before the current hit. A freshly installed entry has the flag clear.
- R6: A write hit (`reqType` 1) sets the entry's dirty flag, and read and execute hits leave it unchanged. `respWasDirty` shows the flag as it stood before the current hit. A freshly installed entry has the flag clear.
- R7: `refillPerm` bit 0 grants read, bit 1 grants write and bit 2 grants execute. `reqType` 0 is read, 1 is write, 2 is execute, and 3 is never granted. A matching request that is not granted raises `respFault` with `respPaddr` 0 and `respHit` 0, and leaves the referenced and dirty flags unchanged.
- R8: A refill goes into the lowest-numbered invalid slot. When all 8 slots are valid, a round-robin pointer picks the victim. The pointer starts at slot 0 after reset and advances by one, wrapping, after each replacement of a valid slot.
- R9: A cycle with `flush` high invalidates every entry, so the next request to any page misses.
- R10: On a hit, `respCache` returns the cache-control field that was installed with the entry.
- R11: At most one entry matches a page number, and at most one of `respHit`, `respFault` and `respStall` is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate every entry |
| reqValid | input | 1 | Request present, held until hit or fault |
| reqVaddr | input | 32 | Virtual address |
| reqType | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| respHit | output | 1 | Translation delivered this cycle |
| respFault | output | 1 | Access kind not granted |
| respStall | output | 1 | Miss, request must be held |
| respPaddr | output | 32 | Physical address, 0 unless hit |
| respCache | output | 2 | Cache-control field of the hit entry |
| respWasRef | output | 1 | Referenced flag before this hit |
| respWasDirty | output | 1 | Dirty flag before this hit |
| walkReq | output | 1 | Walk request to the page table walker |
| walkVpn | output | 20 | Page number to walk |
| refillValid | input | 1 | Walker answer present |
| refillPfn | input | 20 | Frame number to install |
| refillPerm | input | 3 | Grants: bit 0 read, bit 1 write, bit 2 execute |
| refillCache | input | 2 | Cache-control field to install |

## Verification
On every cycle the assertions check several properties. The page-number match stays unique, and hit, fault and stall stay exclusive. A miss opens a walk, and an accepted refill closes it. A hit leaves the referenced flag set, a write hit leaves the dirty flag set, and a flush empties the valid set. A refill into a non-full buffer grows the valid count by exactly one. Only the bench's scenarios can show the things that depend on history across many requests. These include which entry a replacement evicts once the buffer is full, how the round-robin pointer wraps, the fact that a fault leaves the flags untouched, and the exact two-cycle latency from miss to hit under the behavioural reference model.

// File: rtl/xlb_pkg.sv
package xlb_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } accKind_t;

  // strobes from control to datapath
  typedef struct packed {
    logic captureVpn;
    logic refillWrite;
    logic touch;
  } ctrlStrobe_t;
endpackage

// File: rtl/xlb_datapath.sv
module xlb_datapath
  import xlb_pkg::*;
#(
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int OFF_W   = 12,
  parameter int ENTRIES = 8,
  parameter int CC_W    = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                flush,
  input  logic [VA_W-1:0]     reqVaddr,
  input  logic [1:0]          reqType,
  input  logic [PA_W-OFF_W-1:0] refillPfn,
  input  logic [2:0]          refillPerm,
  input  logic [CC_W-1:0]     refillCache,
  input  ctrlStrobe_t         strb,
  output logic                anyMatch,
  output logic                permitOk,
  output logic [PA_W-1:0]     hitPaddr,
  output logic [CC_W-1:0]     hitCache,
  output logic                hitRef,
  output logic                hitDirty,
  output logic [VA_W-OFF_W-1:0] latchedVpn
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PFN_W = PA_W - OFF_W;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] vldQ, refQ, dirtyQ, matchVec;
  logic [VPN_W-1:0]   tagQ  [ENTRIES];
  logic [PFN_W-1:0]   pfnQ  [ENTRIES];
  logic [2:0]         permQ [ENTRIES];
  logic [CC_W-1:0]    ccQ   [ENTRIES];
  logic [IDX_W-1:0]   rrQ, hitIdx, victim;
  logic [VPN_W-1:0]   vpnQ;
  logic               allValid;

  wire [VPN_W-1:0] reqVpn = reqVaddr[VA_W-1:OFF_W];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign matchVec[g] = vldQ[g] && (tagQ[g] == reqVpn);
  end

  always_comb begin
    hitIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (matchVec[i]) hitIdx = IDX_W'(i);
    end
  end

  assign anyMatch = |matchVec;
  assign allValid = &vldQ;

  always_comb begin
    unique case (accKind_t'(reqType))
      ACC_READ:  permitOk = permQ[hitIdx][0];
      ACC_WRITE: permitOk = permQ[hitIdx][1];
      ACC_EXEC:  permitOk = permQ[hitIdx][2];
      default:   permitOk = 1'b0;
    endcase
  end

  // lowest free slot first, else round-robin pointer
  always_comb begin
    victim = rrQ;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!vldQ[i]) victim = IDX_W'(i);
    end
  end

  assign hitPaddr   = {pfnQ[hitIdx], reqVaddr[OFF_W-1:0]};
  assign hitCache   = ccQ[hitIdx];
  assign hitRef     = refQ[hitIdx];
  assign hitDirty   = dirtyQ[hitIdx];
  assign latchedVpn = vpnQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vldQ   <= '0;
      refQ   <= '0;
      dirtyQ <= '0;
      rrQ    <= '0;
      vpnQ   <= '0;
    end else begin
      if (strb.captureVpn) vpnQ <= reqVpn;
      if (strb.touch) begin
        refQ[hitIdx] <= 1'b1;
        if (reqType == ACC_WRITE) dirtyQ[hitIdx] <= 1'b1;
      end
      if (flush) vldQ <= '0;
      if (strb.refillWrite) begin
        vldQ[victim]   <= 1'b1;
        refQ[victim]   <= 1'b0;
        dirtyQ[victim] <= 1'b0;
        if (allValid) rrQ <= (rrQ == IDX_W'(ENTRIES - 1)) ? '0 : rrQ + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strb.refillWrite) begin
      tagQ[victim]  <= vpnQ;
      pfnQ[victim]  <= refillPfn;
      permQ[victim] <= refillPerm;
      ccQ[victim]   <= refillCache;
    end
  end

  a_r11_single_match: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(matchVec));

  a_r5_ref_after_hit: assert property (@(posedge clk) disable iff (!rstN)
    strb.touch && !strb.refillWrite |=> refQ[$past(hitIdx)]);

  a_r6_dirty_after_write: assert property (@(posedge clk) disable iff (!rstN)
    strb.touch && !strb.refillWrite && reqType == ACC_WRITE |=> dirtyQ[$past(hitIdx)]);

  a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rstN)
    flush && !strb.refillWrite |=> vldQ == '0);

  a_r8_free_slot_used: assert property (@(posedge clk) disable iff (!rstN)
    strb.refillWrite && !allValid && !flush |=>
      $countones(vldQ) == $countones($past(vldQ)) + 1);
endmodule

// File: rtl/xlb_control.sv
module xlb_control
  import xlb_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        anyMatch,
  input  logic        permitOk,
  input  logic        refillValid,
  output ctrlStrobe_t strb,
  output logic        walkReq,
  output logic        respHit,
  output logic        respFault,
  output logic        respStall
);
  logic walkQ;

  assign respHit   = reqValid && anyMatch && permitOk;
  assign respFault = reqValid && anyMatch && !permitOk;
  assign respStall = reqValid && !anyMatch;
  assign walkReq   = walkQ;

  assign strb.captureVpn  = !walkQ && respStall;
  assign strb.refillWrite = walkQ && refillValid;
  assign strb.touch       = respHit;

  always_ff @(posedge clk) begin
    if (!rstN)                walkQ <= 1'b0;
    else if (strb.refillWrite) walkQ <= 1'b0;
    else if (strb.captureVpn)  walkQ <= 1'b1;
  end

  a_r3_walk_follows_miss: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !anyMatch && !walkQ |=> walkReq);

  a_r4_walk_closes: assert property (@(posedge clk) disable iff (!rstN)
    walkReq && refillValid |=> !walkReq);

  a_r3_walk_held: assert property (@(posedge clk) disable iff (!rstN)
    walkReq && !refillValid |=> walkReq);

  a_r11_resp_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({respHit, respFault, respStall}));
endmodule

// File: rtl/xlate_buffer.sv
module xlate_buffer
  import xlb_pkg::*;
#(
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int OFF_W   = 12,
  parameter int ENTRIES = 8,
  parameter int CC_W    = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  flush,
  input  logic                  reqValid,
  input  logic [VA_W-1:0]       reqVaddr,
  input  logic [1:0]            reqType,
  output logic                  respHit,
  output logic                  respFault,
  output logic                  respStall,
  output logic [PA_W-1:0]       respPaddr,
  output logic [CC_W-1:0]       respCache,
  output logic                  respWasRef,
  output logic                  respWasDirty,
  output logic                  walkReq,
  output logic [VA_W-OFF_W-1:0] walkVpn,
  input  logic                  refillValid,
  input  logic [PA_W-OFF_W-1:0] refillPfn,
  input  logic [2:0]            refillPerm,
  input  logic [CC_W-1:0]       refillCache
);
  ctrlStrobe_t     strb;
  logic            anyMatch, permitOk, hitRef, hitDirty;
  logic [PA_W-1:0] hitPaddr;
  logic [CC_W-1:0] hitCache;

  xlb_control i_control (
    .clk, .rstN, .reqValid, .anyMatch, .permitOk, .refillValid,
    .strb, .walkReq, .respHit, .respFault, .respStall
  );

  xlb_datapath #(
    .VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W), .ENTRIES(ENTRIES), .CC_W(CC_W)
  ) i_datapath (
    .clk, .rstN, .flush, .reqVaddr, .reqType, .refillPfn, .refillPerm,
    .refillCache, .strb, .anyMatch, .permitOk, .hitPaddr, .hitCache,
    .hitRef, .hitDirty, .latchedVpn(walkVpn)
  );

  assign respPaddr    = respHit ? hitPaddr : '0;
  assign respCache    = respHit ? hitCache : '0;
  assign respWasRef   = respHit && hitRef;
  assign respWasDirty = respHit && hitDirty;

  a_r7_fault_no_address: assert property (@(posedge clk) disable iff (!rstN)
    respFault |-> respPaddr == '0 && !respHit);
endmodule

// File: tb/test_xlate_buffer.sv
module test_xlate_buffer;
  logic        clk = 0, rstN = 0, flush = 0, reqValid = 0;
  logic [31:0] reqVaddr = 0;
  logic [1:0]  reqType = 0;
  logic        respHit, respFault, respStall, respWasRef, respWasDirty, walkReq;
  logic [31:0] respPaddr;
  logic [1:0]  respCache;
  logic [19:0] walkVpn;
  logic        refillValid = 0;
  logic [19:0] refillPfn = 0;
  logic [2:0]  refillPerm = 0;
  logic [1:0]  refillCache = 0;

  xlate_buffer i_xlate_buffer (.*);

  always #5 clk = ~clk;

  int unsigned nTests = 0, nFail = 0;
  bit done = 0;
  logic [2:0] curPerm = 3'b111;
  logic [1:0] curCache = 2'd0;

  // behavioural reference model
  bit        mVld[8], mRef[8], mDirty[8];
  bit [19:0] mVpn[8], mPfn[8];
  bit [2:0]  mPerm[8];
  bit [1:0]  mCc[8];
  int        mRr = 0;
  bit        mWalk = 0;
  bit [19:0] mWalkVpn = 0;

  function automatic bit [19:0] pfnOf(input bit [19:0] v);
    return v ^ 20'hA5C3F;
  endfunction

  function automatic bit allowed(input bit [2:0] p, input bit [1:0] k);
    if (k == 2'd3) return 1'b0;
    return p[k];
  endfunction

  function automatic int findMatch(input bit [19:0] v);
    int r = -1;
    for (int i = 0; i < 8; i++) if (mVld[i] && mVpn[i] == v) r = i;
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 8; i++) begin mVld[i] = 0; mRef[i] = 0; mDirty[i] = 0; end
      mRr = 0; mWalk = 0; mWalkVpn = 0;
    end else begin
      int mi, vic;
      bit full;
      mi = findMatch(reqVaddr[31:12]);
      full = 1;
      vic = mRr;
      for (int i = 7; i >= 0; i--) if (!mVld[i]) begin full = 0; vic = i; end
      if (reqValid && mi >= 0 && allowed(mPerm[mi], reqType)) begin
        mRef[mi] = 1;
        if (reqType == 2'd1) mDirty[mi] = 1;
      end
      if (flush) for (int i = 0; i < 8; i++) mVld[i] = 0;
      if (mWalk && refillValid) begin
        mVld[vic] = 1; mRef[vic] = 0; mDirty[vic] = 0;
        mVpn[vic] = mWalkVpn; mPfn[vic] = refillPfn;
        mPerm[vic] = refillPerm; mCc[vic] = refillCache;
        if (full) mRr = (mRr + 1) % 8;
        mWalk = 0;
      end else if (!mWalk && reqValid && mi < 0) begin
        mWalk = 1; mWalkVpn = reqVaddr[31:12];
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    int mi;
    bit eHit, eFault, eStall;
    mi = findMatch(reqVaddr[31:12]);
    eHit   = reqValid && mi >= 0 && allowed(mPerm[mi], reqType);
    eFault = reqValid && mi >= 0 && !allowed(mPerm[mi], reqType);
    eStall = reqValid && mi < 0;
    chk("R2 hit", respHit, eHit);
    chk("R7 fault", respFault, eFault);
    chk("R3 stall", respStall, eStall);
    chk("R4 walkReq", walkReq, mWalk);
    if (mWalk) chk("R3 walkVpn", walkVpn, mWalkVpn);
    chk("R2 paddr", respPaddr, eHit ? {mPfn[mi], reqVaddr[11:0]} : 32'd0);
    if (eHit) begin
      chk("R10 cache", respCache, mCc[mi]);
      chk("R5 wasRef", respWasRef, mRef[mi]);
      chk("R6 wasDirty", respWasDirty, mDirty[mi]);
    end
  endtask

  task automatic tick();
    #1 compareAll();
    @(negedge clk);
  endtask

  // holds a request until hit or fault, acting as the walker
  task automatic access(input bit [19:0] vpn, input bit [11:0] off, input bit [1:0] kind,
                        output bit hit, output bit fault, output bit sawWalk,
                        output int cycles, output logic [31:0] pa,
                        output bit wRef, output bit wDirty, output logic [1:0] cc);
    hit = 0; fault = 0; sawWalk = 0; cycles = -1; pa = 0; wRef = 0; wDirty = 0; cc = 0;
    reqValid = 1; reqVaddr = {vpn, off}; reqType = kind;
    for (int n = 0; n < 20; n++) begin
      #1 compareAll();
      if (respHit || respFault) begin
        hit = respHit; fault = respFault; cycles = n; pa = respPaddr;
        wRef = respWasRef; wDirty = respWasDirty; cc = respCache;
        break;
      end
      if (walkReq) begin
        sawWalk = 1;
        refillValid = 1; refillPfn = pfnOf(walkVpn);
        refillPerm = curPerm; refillCache = curCache;
      end
      @(negedge clk);
      refillValid = 0;
    end
    @(negedge clk);
    reqValid = 0;
  endtask

  task automatic pulseFlush();
    flush = 1;
    tick();
    flush = 0;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      nTests++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    bit h, f, w, rr, rd;
    int c;
    logic [31:0] pa;
    logic [1:0] cc;

    repeat (3) @(negedge clk);
    rstN = 1;
    // R1: reset state
    #1;
    chk("R1 respHit after reset", respHit, 0);
    chk("R1 respStall after reset", respStall, 0);
    chk("R1 walkReq after reset", walkReq, 0);
    chk("R1 respPaddr after reset", respPaddr, 0);
    @(negedge clk);

    curPerm = 3'b111; curCache = 2'd2;
    access(20'h12345, 12'hABC, 2'd0, h, f, w, c, pa, rr, rd, cc);
    chk("R1 first access walks", w, 1);
    chk("R4 miss resolves in 2 cycles", c, 2);
    chk("R2 translated address", pa, {pfnOf(20'h12345), 12'hABC});
    chk("R10 cache field", cc, 2);
    chk("R5 fresh entry not referenced", rr, 0);

    access(20'h12345, 12'h001, 2'd0, h, f, w, c, pa, rr, rd, cc);
    chk("R2 hit without walk", w, 0);
    chk("R2 hit same cycle", c, 0);
    chk("R5 referenced after hit", rr, 1);
    chk("R6 read leaves clean", rd, 0);

    access(20'h12345, 12'h002, 2'd1, h, f, w, c, pa, rr, rd, cc);
    chk("R6 clean before write", rd, 0);
    access(20'h12345, 12'h003, 2'd0, h, f, w, c, pa, rr, rd, cc);
    chk("R6 dirty after write", rd, 1);

    access(20'h12345, 12'h004, 2'd3, h, f, w, c, pa, rr, rd, cc);
    chk("R7 reserved kind faults", f, 1);
    chk("R7 fault address zero", pa, 0);

    curPerm = 3'b001; curCache = 2'd1;
    access(20'h00042, 12'h010, 2'd1, h, f, w, c, pa, rr, rd, cc);
    chk("R7 write denied", f, 1);
    access(20'h00042, 12'h010, 2'd2, h, f, w, c, pa, rr, rd, cc);
    chk("R7 exec denied", f, 1);
    access(20'h00042, 12'h010, 2'd0, h, f, w, c, pa, rr, rd, cc);
    chk("R7 read granted", h, 1);
    chk("R7 faults left dirty clear", rd, 0);
    chk("R7 faults left ref clear", rr, 0);

    curPerm = 3'b110;
    access(20'h00077, 12'h020, 2'd0, h, f, w, c, pa, rr, rd, cc);
    chk("R7 read denied", f, 1);
    access(20'h00077, 12'h020, 2'd2, h, f, w, c, pa, rr, rd, cc);
    chk("R7 exec granted", h, 1);

    // R9
    pulseFlush();
    access(20'h12345, 12'h000, 2'd0, h, f, w, c, pa, rr, rd, cc);
    chk("R9 flush forces miss", w, 1);

    // R8 replacement order
    curPerm = 3'b111;
    pulseFlush();
    for (int i = 0; i < 8; i++) begin
      access(20'h00100 + 20'(i), 12'h0, 2'd0, h, f, w, c, pa, rr, rd, cc);
      chk("R8 fill walks", w, 1);
    end
    access(20'h00107, 12'h0, 2'd0, h, f, w, c, pa, rr, rd, cc);
    chk("R8 free slots filled first", w, 0);
    access(20'h00200, 12'h0, 2'd0, h, f, w, c, pa, rr, rd, cc);
    access(20'h00101, 12'h0, 2'd0, h, f, w, c, pa, rr, rd, cc);
    chk("R8 slot 1 survives first eviction", w, 0);
    access(20'h00100, 12'h0, 2'd0, h, f, w, c, pa, rr, rd, cc);
    chk("R8 slot 0 was evicted", w, 1);
    access(20'h00102, 12'h0, 2'd0, h, f, w, c, pa, rr, rd, cc);
    chk("R8 slot 2 survives", w, 0);
    access(20'h00101, 12'h0, 2'd0, h, f, w, c, pa, rr, rd, cc);
    chk("R8 pointer advanced to slot 1", w, 1);
    for (int i = 0; i < 8; i++) tick();

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule